// File: doc/BRIEF.md
# Prioritized Processor Interrupt Arbiter

This block sits between a processor core's pending-interrupt bits and its exception entry logic. The owners of fourteen asynchronous interrupt sources hold their pending bits. The arbiter masks those bits with the core's enable state and the partition control bits, then picks the highest-priority eligible source. It hands the chosen cause to the core with a single-cycle deliver strobe and waits for the core's acknowledge before it picks again.

Some sources are cleared by the act of delivery. For those the arbiter emits a one-cycle clear pulse to the source owner, in the same cycle as the strobe. Level-style sources, such as the external and critical external inputs, keep their pending bit until their owner drops it. The decrementer clears on delivery only when a configuration input asks for it. A summary hard-request output tells the core whether any pending bit will survive the current delivery.

Top module: `intr_arbiter`

## Requirements
- R1: While reset is held, and in the first cycle after it, `deliver_o`, `src_clr_o` and `busy_o` are 0 and `cause_o` is the none code 14.
- R2: Source indices give the priority, with 0 highest: 0 reset, 1 machine check, 2 debug, 3 hypervisor decrementer, 4 external, 5 critical external, 6 watchdog, 7 critical doorbell, 8 fixed-interval timer, 9 programmable-interval timer, 10 decrementer, 11 doorbell, 12 performance monitor, 13 thermal. The block delivers the lowest-index eligible source. `cause_o` carries that index and `cause_oh_o` has only bit index set.
- R3: A selection is registered, so the strobe appears the cycle after the request is seen. `deliver_o` is high for exactly one cycle per selection. `cause_o` and `cause_oh_o` stay stable, and no new selection is made, until `core_ack_i` is seen. On the edge that samples the acknowledge, the outputs return to the none code.
- R4: When no source is eligible, `cause_o` is 14, `cause_oh_o` is 0 and no strobe is issued.
- R5: The hypervisor decrementer (3) is eligible only when `part_hdec_en_i` is 1 and either `ext_en_i` is 1 or `hv_mode_i` is 0. A gated source does not block lower-priority sources.
- R6: The external source (4) is eligible when `ext_en_i` is 1. It is also eligible when `hv_support_i` is 1, `hv_mode_i` is 0 and `part_ext_guest_i` is 0.
- R7: Reset, machine check and debug (0 to 2) need no enable. Critical external, watchdog and critical doorbell (5 to 7) need `crit_en_i`. Sources 8 to 13 need `ext_en_i`.
- R8: With the strobe, `src_clr_o` pulses the bit of the delivered source for sources 0, 1, 2, 3, 6, 7, 8, 9, 11, 12 and 13. It never pulses for external (4) or critical external (5).
- R9: A delivered decrementer (10) gets a clear pulse only if `dec_auto_clr_i` is 1.
- R10: `hard_req_o` is 1 exactly when some bit of `irq_pend_i` is set that is not being cleared by `src_clr_o` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_pend_i | input | 14 | Pending bit per source, index order as in R2 |
| ext_en_i | input | 1 | Core external-interrupt enable |
| crit_en_i | input | 1 | Core critical-interrupt enable |
| hv_mode_i | input | 1 | Core is running in hypervisor mode |
| hv_support_i | input | 1 | Core implements hypervisor mode |
| part_ext_guest_i | input | 1 | Partition control: external interrupts honour the enable in guest mode |
| part_hdec_en_i | input | 1 | Partition control: hypervisor decrementer enable |
| dec_auto_clr_i | input | 1 | Decrementer clears on delivery |
| core_ack_i | input | 1 | Core has taken the delivered cause |
| deliver_o | output | 1 | One-cycle deliver strobe |
| cause_o | output | 4 | Selected source index, 14 when none |
| cause_oh_o | output | 14 | Selected source, one-hot |
| src_clr_o | output | 14 | Clear-on-delivery pulses to the source owners |
| busy_o | output | 1 | A delivered cause awaits acknowledge |
| hard_req_o | output | 1 | Pending work remains after this cycle's clears |

## Verification
The priority order is exercised with a descending staircase of pending sets, where every source from index k downward is pending. Each step must pick exactly k, which separates a correct order from a swapped or reversed one and shows every clear-pulse bit. The gating cases raise a gated source together with a lower one. Selecting the lower source shows the gate is open, and selecting nothing tells gating apart from blocking. A held grant is also checked: a higher-priority request arrives before the acknowledge, and it must not displace the delivered cause until the acknowledge comes.

// File: rtl/intr_arb_pkg.sv
// Shared constants for the interrupt arbiter: source indices (priority order,
// index 0 highest), class masks and the sequencer state type.
package intr_arb_pkg;

    localparam int NUM_SRC = 14;
    localparam int CAUSE_W = $clog2(NUM_SRC + 1);

    // Source indices; a lower index wins arbitration.
    localparam int SRC_RESET  = 0;
    localparam int SRC_MCHK   = 1;
    localparam int SRC_DEBUG  = 2;
    localparam int SRC_HDEC   = 3;
    localparam int SRC_EXT    = 4;
    localparam int SRC_CEXT   = 5;
    localparam int SRC_WDOG   = 6;
    localparam int SRC_CDBELL = 7;
    localparam int SRC_FIXT   = 8;
    localparam int SRC_PIT    = 9;
    localparam int SRC_DEC    = 10;
    localparam int SRC_DBELL  = 11;
    localparam int SRC_PERF   = 12;
    localparam int SRC_THERM  = 13;

    typedef logic [NUM_SRC-1:0] src_vec_t;
    typedef logic [CAUSE_W-1:0] cause_t;

    localparam cause_t CAUSE_NONE = cause_t'(NUM_SRC);

    // Sources delivered without any enable.
    localparam src_vec_t MASK_ALWAYS = src_vec_t'((1 << SRC_RESET) | (1 << SRC_MCHK) | (1 << SRC_DEBUG));
    // Critical class, gated by the critical enable.
    localparam src_vec_t MASK_CRIT   = src_vec_t'((1 << SRC_CEXT) | (1 << SRC_WDOG) | (1 << SRC_CDBELL));
    // Ordinary class, gated by the external enable.
    localparam src_vec_t MASK_ORD    = src_vec_t'((1 << SRC_FIXT) | (1 << SRC_PIT) | (1 << SRC_DEC) |
                                                  (1 << SRC_DBELL) | (1 << SRC_PERF) | (1 << SRC_THERM));
    // Sources that always clear on delivery (decrementer handled separately).
    localparam src_vec_t MASK_SELFCLR = src_vec_t'((1 << SRC_RESET) | (1 << SRC_MCHK) | (1 << SRC_DEBUG) |
                                                   (1 << SRC_HDEC) | (1 << SRC_WDOG) | (1 << SRC_CDBELL) |
                                                   (1 << SRC_FIXT) | (1 << SRC_PIT) | (1 << SRC_DBELL) |
                                                   (1 << SRC_PERF) | (1 << SRC_THERM));

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } arb_state_t;

endpackage

// File: rtl/intr_arb_gate.sv
// Enable gating: turns raw pending bits into eligible bits using the core
// enables and partition control, and builds the per-source clear mask.
// Assumes pending bits are already synchronous to clk.
module intr_arb_gate
    import intr_arb_pkg::*;
(
    input  logic     [NUM_SRC-1:0] pend_i,
    input  logic                   ext_en_i,
    input  logic                   crit_en_i,
    input  logic                   hv_mode_i,
    input  logic                   hv_support_i,
    input  logic                   part_ext_guest_i,
    input  logic                   part_hdec_en_i,
    input  logic                   dec_auto_clr_i,
    output logic     [NUM_SRC-1:0] elig_o,
    output logic     [NUM_SRC-1:0] clr_mask_o
);

    src_vec_t class_en;
    logic     hdec_ok;
    logic     ext_ok;

    // Purpose: enable mask per priority class.
    always_comb begin
        class_en = MASK_ALWAYS;
        if (crit_en_i) class_en = class_en | MASK_CRIT;
        if (ext_en_i)  class_en = class_en | MASK_ORD;
    end

    // Purpose: special conditions for the hypervisor timer and external input.
    always_comb begin
        hdec_ok = part_hdec_en_i && (ext_en_i || !hv_mode_i);
        ext_ok  = ext_en_i || (hv_support_i && !hv_mode_i && !part_ext_guest_i);
    end

    // Purpose: combine class and special gating into eligible bits.
    always_comb begin
        elig_o           = pend_i & class_en;
        elig_o[SRC_HDEC] = pend_i[SRC_HDEC] && hdec_ok;
        elig_o[SRC_EXT]  = pend_i[SRC_EXT] && ext_ok;
    end

    // Purpose: which sources get a clear pulse when delivered.
    always_comb begin
        clr_mask_o          = MASK_SELFCLR;
        clr_mask_o[SRC_DEC] = dec_auto_clr_i;
    end

endmodule

// File: rtl/intr_arb_prio.sv
// Fixed-priority picker: bit 0 wins. Produces a one-hot grant, its index
// and an any-eligible flag. Purely combinational.
module intr_arb_prio #(
    parameter int N   = 14,
    parameter int IDX_W = $clog2(N + 1)
) (
    input  logic [N-1:0]     req_i,
    output logic [N-1:0]     grant_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             any_o
);

    logic [N:0] higher;

    assign higher[0] = 1'b0;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_chain
            // Purpose: a bit is granted when no lower index is requesting.
            assign grant_o[g]  = req_i[g] && !higher[g];
            assign higher[g+1] = higher[g] || req_i[g];
        end
    endgenerate

    assign any_o = higher[N];

    // Purpose: encode the granted bit; N means nothing granted.
    always_comb begin
        idx_o = IDX_W'(N);
        for (int i = N - 1; i >= 0; i--) begin
            if (grant_o[i]) idx_o = IDX_W'(i);
        end
    end

endmodule

// File: rtl/intr_arb_seq.sv
// Delivery sequencer: registers a grant, strobes it once with its clear
// pulses, holds the cause until the core acknowledges, then re-arms.
// Assumes the acknowledge is a level or pulse sampled only while waiting.
module intr_arb_seq
    import intr_arb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] grant_i,
    input  cause_t             idx_i,
    input  logic               any_i,
    input  logic [NUM_SRC-1:0] clr_mask_i,
    input  logic               ack_i,
    output logic               deliver_o,
    output cause_t             cause_o,
    output logic [NUM_SRC-1:0] cause_oh_o,
    output logic [NUM_SRC-1:0] src_clr_o,
    output logic               busy_o
);

    arb_state_t state_q;

    // Purpose: state, strobe, cause and clear registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            deliver_o  <= 1'b0;
            cause_o    <= CAUSE_NONE;
            cause_oh_o <= '0;
            src_clr_o  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (any_i) begin
                        state_q    <= ST_WAIT;
                        deliver_o  <= 1'b1;
                        cause_o    <= idx_i;
                        cause_oh_o <= grant_i;
                        src_clr_o  <= grant_i & clr_mask_i;
                    end else begin
                        deliver_o  <= 1'b0;
                        cause_o    <= CAUSE_NONE;
                        cause_oh_o <= '0;
                        src_clr_o  <= '0;
                    end
                end
                default: begin
                    deliver_o <= 1'b0;
                    src_clr_o <= '0;
                    if (ack_i) begin
                        state_q    <= ST_IDLE;
                        cause_o    <= CAUSE_NONE;
                        cause_oh_o <= '0;
                    end
                end
            endcase
        end
    end

    assign busy_o = (state_q == ST_WAIT);

    AST_STROBE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        deliver_o |=> !deliver_o); // R3
    AST_HOLD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !ack_i) |=> ($stable(cause_o) && $stable(cause_oh_o) && busy_o)); // R3
    AST_IDLE_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (cause_o == CAUSE_NONE && !deliver_o && cause_oh_o == '0)); // R4
    AST_CLR_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (src_clr_o != '0) |-> (deliver_o && (src_clr_o & ~cause_oh_o) == '0)); // R8
    AST_ONE_HOT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> $onehot(cause_oh_o)); // R2

endmodule

// File: rtl/intr_arbiter.sv
// Prioritized processor interrupt arbiter (top). Gates pending bits, picks
// the highest-priority eligible source, delivers it with a handshake and
// reports whether pending work remains. Pending bits are owned outside.
module intr_arbiter
    import intr_arb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [13:0] irq_pend_i,
    input  logic        ext_en_i,
    input  logic        crit_en_i,
    input  logic        hv_mode_i,
    input  logic        hv_support_i,
    input  logic        part_ext_guest_i,
    input  logic        part_hdec_en_i,
    input  logic        dec_auto_clr_i,
    input  logic        core_ack_i,
    output logic        deliver_o,
    output logic [3:0]  cause_o,
    output logic [13:0] cause_oh_o,
    output logic [13:0] src_clr_o,
    output logic        busy_o,
    output logic        hard_req_o
);

    src_vec_t elig;
    src_vec_t clr_mask;
    src_vec_t grant;
    cause_t   grant_idx;
    logic     grant_any;

    intr_arb_gate i_gate (
        .pend_i           (irq_pend_i),
        .ext_en_i         (ext_en_i),
        .crit_en_i        (crit_en_i),
        .hv_mode_i        (hv_mode_i),
        .hv_support_i     (hv_support_i),
        .part_ext_guest_i (part_ext_guest_i),
        .part_hdec_en_i   (part_hdec_en_i),
        .dec_auto_clr_i   (dec_auto_clr_i),
        .elig_o           (elig),
        .clr_mask_o       (clr_mask)
    );

    intr_arb_prio #(.N(NUM_SRC), .IDX_W(CAUSE_W)) i_prio (
        .req_i   (elig),
        .grant_o (grant),
        .idx_o   (grant_idx),
        .any_o   (grant_any)
    );

    intr_arb_seq i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .grant_i    (grant),
        .idx_i      (grant_idx),
        .any_i      (grant_any),
        .clr_mask_i (clr_mask),
        .ack_i      (core_ack_i),
        .deliver_o  (deliver_o),
        .cause_o    (cause_o),
        .cause_oh_o (cause_oh_o),
        .src_clr_o  (src_clr_o),
        .busy_o     (busy_o)
    );

    // Purpose: pending work survives this cycle's clear pulses.
    assign hard_req_o = |(irq_pend_i & ~src_clr_o);

    AST_HDEC_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (deliver_o && cause_o == cause_t'(SRC_HDEC)) |->
        ($past(part_hdec_en_i) && ($past(ext_en_i) || !$past(hv_mode_i)))); // R5
    AST_EXT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (deliver_o && cause_o == cause_t'(SRC_EXT)) |->
        ($past(ext_en_i) || ($past(hv_support_i) && !$past(hv_mode_i) && !$past(part_ext_guest_i)))); // R6
    AST_CRIT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (deliver_o && (cause_oh_o & MASK_CRIT) != '0) |-> $past(crit_en_i)); // R7
    AST_LEVEL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (deliver_o && (cause_o == cause_t'(SRC_EXT) || cause_o == cause_t'(SRC_CEXT))) |-> (src_clr_o == '0)); // R8
    AST_DEC_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (deliver_o && cause_o == cause_t'(SRC_DEC)) |-> (src_clr_o[SRC_DEC] == $past(dec_auto_clr_i))); // R9

endmodule

// File: tb/test_intr_arbiter.sv
module test_intr_arbiter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] irq_pend_i = '0;
    logic        ext_en_i = 1'b0, crit_en_i = 1'b0, hv_mode_i = 1'b0, hv_support_i = 1'b0;
    logic        part_ext_guest_i = 1'b0, part_hdec_en_i = 1'b0, dec_auto_clr_i = 1'b0;
    logic        core_ack_i = 1'b0;
    logic        deliver_o, busy_o, hard_req_o;
    logic [3:0]  cause_o;
    logic [13:0] cause_oh_o, src_clr_o;

    int n_run = 0;
    int n_fail = 0;
    localparam int NONE = 14;

    always #10 clk = ~clk;

    intr_arbiter i_intr_arbiter (
        .clk(clk), .rst_n(rst_n), .irq_pend_i(irq_pend_i),
        .ext_en_i(ext_en_i), .crit_en_i(crit_en_i), .hv_mode_i(hv_mode_i),
        .hv_support_i(hv_support_i), .part_ext_guest_i(part_ext_guest_i),
        .part_hdec_en_i(part_hdec_en_i), .dec_auto_clr_i(dec_auto_clr_i),
        .core_ack_i(core_ack_i), .deliver_o(deliver_o), .cause_o(cause_o),
        .cause_oh_o(cause_oh_o), .src_clr_o(src_clr_o), .busy_o(busy_o),
        .hard_req_o(hard_req_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Expected clear pulse for a delivered source (R8, R9).
    function automatic logic [13:0] exp_clr(input int idx, input logic dec_clr);
        if (idx == 4 || idx == 5 || idx >= NONE) return '0;
        if (idx == 10) return dec_clr ? 14'(1 << 10) : '0;
        return 14'(1 << idx);
    endfunction

    // Present a pending set, check the selection, then acknowledge.
    task automatic take(input logic [13:0] pend, input int exp, input string req);
        logic [13:0] ec;
        ec = exp_clr(exp, dec_auto_clr_i);
        @(negedge clk);
        irq_pend_i = pend;
        @(negedge clk);
        chk(req, {31'd0, deliver_o}, (exp != NONE) ? 32'd1 : 32'd0);
        chk(req, {28'd0, cause_o}, 32'(exp));
        chk(req, {18'd0, cause_oh_o}, (exp != NONE) ? 32'(1 << exp) : 32'd0);
        chk(req, {18'd0, src_clr_o}, {18'd0, ec});
        chk("R10", {31'd0, hard_req_o}, {31'd0, |(pend & ~ec)});
        irq_pend_i = '0;
        core_ack_i = 1'b1;
        @(negedge clk);
        core_ack_i = 1'b0;
        chk(req, {28'd0, cause_o}, 32'(NONE));
        chk(req, {31'd0, busy_o}, 32'd0);
    endtask

    task automatic set_cfg(input logic ee, input logic ce, input logic hv, input logic hvs,
                           input logic guest, input logic hden, input logic dcl);
        ext_en_i = ee; crit_en_i = ce; hv_mode_i = hv; hv_support_i = hvs;
        part_ext_guest_i = guest; part_hdec_en_i = hden; dec_auto_clr_i = dcl;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", {31'd0, deliver_o}, 32'd0);
        chk("R1", {28'd0, cause_o}, 32'(NONE));
        chk("R1", {18'd0, src_clr_o}, 32'd0);
        chk("R1", {31'd0, busy_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", {28'd0, cause_o}, 32'(NONE));
        chk("R1", {31'd0, deliver_o}, 32'd0);
    endtask

    task automatic t_priority();
        set_cfg(1, 1, 0, 0, 1, 1, 1);
        for (int k = 0; k < 14; k++) take(14'h3fff << k, k, "R2 R8");
        set_cfg(1, 1, 0, 0, 1, 1, 0);
        take(14'h3c00, 10, "R9");
        set_cfg(1, 1, 0, 0, 1, 1, 1);
        take(14'h0400, 10, "R9");
    endtask

    task automatic t_hold();
        set_cfg(1, 1, 0, 0, 1, 1, 1);
        @(negedge clk);
        irq_pend_i = 14'h2000;
        @(negedge clk);
        chk("R3", {31'd0, deliver_o}, 32'd1);
        irq_pend_i = 14'h0001;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk("R3", {31'd0, deliver_o}, 32'd0);
            chk("R3", {28'd0, cause_o}, 32'd13);
            chk("R3", {31'd0, busy_o}, 32'd1);
        end
        core_ack_i = 1'b1;
        @(negedge clk);
        core_ack_i = 1'b0;
        chk("R3", {28'd0, cause_o}, 32'(NONE));
        @(negedge clk);
        chk("R3", {31'd0, deliver_o}, 32'd1);
        chk("R3", {28'd0, cause_o}, 32'd0);
        irq_pend_i = '0;
        core_ack_i = 1'b1;
        @(negedge clk);
        core_ack_i = 1'b0;
    endtask

    task automatic t_none();
        set_cfg(1, 1, 0, 0, 1, 1, 1);
        take(14'h0000, NONE, "R4");
        set_cfg(0, 0, 0, 0, 1, 1, 1);
        take(14'h0010, NONE, "R4");
        take(14'h3f00, NONE, "R7");
    endtask

    task automatic t_hdec();
        set_cfg(1, 1, 1, 1, 1, 0, 1);
        take(14'h2008, 13, "R5");
        set_cfg(0, 1, 1, 1, 1, 1, 1);
        take(14'h0008, NONE, "R5");
        set_cfg(0, 1, 0, 1, 1, 1, 1);
        take(14'h0008, 3, "R5");
        set_cfg(1, 1, 1, 1, 1, 1, 1);
        take(14'h0008, 3, "R5");
    endtask

    task automatic t_ext();
        set_cfg(0, 1, 0, 1, 0, 1, 1);
        take(14'h0010, 4, "R6");
        set_cfg(0, 1, 0, 1, 1, 1, 1);
        take(14'h0030, 5, "R6");
        set_cfg(0, 1, 1, 1, 0, 1, 1);
        take(14'h0010, NONE, "R6");
        set_cfg(0, 0, 0, 0, 0, 1, 1);
        take(14'h0010, NONE, "R6");
        set_cfg(1, 0, 1, 0, 1, 1, 1);
        take(14'h0010, 4, "R6");
    endtask

    task automatic t_classes();
        set_cfg(1, 0, 0, 0, 1, 1, 1);
        take(14'h0140, 8, "R7");
        set_cfg(0, 1, 0, 0, 1, 1, 1);
        take(14'h0140, 6, "R7");
        set_cfg(0, 0, 0, 0, 1, 1, 1);
        take(14'h2002, 1, "R7");
        take(14'h0004, 2, "R7");
        set_cfg(0, 1, 0, 0, 1, 1, 1);
        take(14'h0020, 5, "R8");
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                t_reset();
                t_priority();
                t_hold();
                t_none();
                t_hdec();
                t_ext();
                t_classes();
            end
            begin
                repeat (20000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule